// File: doc/BRIEF.md
# Self-Seeding PRBS Checker with Sampling-Phase Search

This block checks a sampled serial bit stream against a pseudo-random binary sequence that it makes itself. Each received bit arrives with a valid strobe. After a start pulse the block fills its expected-data register from the received bits, so it needs no agreed starting state with the transmitter. It then lets that register run on its own predictions and compares every later received bit with the predicted one.

The first comparisons form a measurement window of programmable length. If the window holds more errors than the threshold allows, the block assumes the sampling point sits near a bit edge. It advances a 3-bit sampling-delay code by one eighth of a bit period and seeds again from fresh received bits. After eight failing windows, one full bit period has been swept, and the block stops and reports failure. A passing window locks the checker. From then on it counts compared bits and bit errors. The counters read zero whenever the checker is not locked. The delay line that acts on the delay code lies outside the block.

Top module: `prbs_phase_checker`

## Requirements
- R1: After reset, `delay_code` is 0, `locked` and `failed` are low, and both counters read 0.
- R2: `poly_sel` is sampled on `start` and picks the sequence b[k] = b[k-n] ^ b[k-t]: code 0 gives n=7 and t=6, code 1 gives n=15 and t=14, codes 2 and 3 both give n=31 and t=28.
- R3: On `start` the delay code takes `init_delay`, `locked` and `failed` clear, and the next n valid bits are shifted into the expected register unchanged, with no comparison made.
- R4: After seeding, each prediction is shifted into the expected register in place of the received bit. A received error therefore costs exactly one counted error and does not spread to later bits.
- R5: A measurement window covers max(`win_len`,1) compared bits. It passes when its error count is less than or equal to `err_thresh`.
- R6: A failing window, other than the eighth since `start`, adds 1 modulo 8 to `delay_code`, and the block seeds again from the next n valid bits.
- R7: The eighth failing window raises `failed`. The delay code then keeps the last value tried, and nothing changes until the next `start`. `locked` and `failed` are never high together.
- R8: While `locked` is low, `bit_count` and `err_count` read 0.
- R9: `locked` rises in the cycle after the last bit of the first passing window and stays high until the next `start`. At that point the counters hold the window's bit count and error count. Each later valid bit adds one to `bit_count`, and each mismatch adds one to `err_count`. Both counters saturate at all ones.
- R10: A cycle with `rx_valid` low has no effect on seeding, windows or counters, whatever `rx_bit` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a new search, one-cycle pulse |
| rx_valid | input | 1 | `rx_bit` carries a sampled bit this cycle |
| rx_bit | input | 1 | Sampled received bit |
| poly_sel | input | 2 | Sequence select, see R2 |
| init_delay | input | DLY_W | First sampling-delay code tried |
| win_len | input | WIN_W | Compared bits per measurement window |
| err_thresh | input | WIN_W | Largest error count a window may hold and pass |
| delay_code | output | DLY_W | Sampling-delay code for the external delay line |
| locked | output | 1 | Checker synchronized |
| failed | output | 1 | Phase sweep exhausted without synchronization |
| bit_count | output | CNT_W | Compared bits since lock |
| err_count | output | CNT_W | Mismatched bits since lock |

## Verification
The bench builds the block with WIN_W=16, DLY_W=3 and CNT_W=8. The narrow counters let a few hundred bits drive both totals into saturation, while window lengths up to 48 still fit with room to spare. The channel model in the bench corrupts the bits of whichever delay codes a vector marks as bad, reading the code the block drives. Each vector therefore sets up its own sweep: wrap from 7 to 0, a lock on the eighth and last phase, a window whose error count sits exactly at the threshold or one above it, a zero-length window, and a stream sent with the wrong polynomial.

// File: rtl/prbs_chk_pkg.sv
package prbs_chk_pkg;

  // Width of the expected-data history; covers the longest sequence.
  localparam int HIST_W = 31;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_SEED = 3'd1,
    ST_MEAS = 3'd2,
    ST_LOCK = 3'd3,
    ST_FAIL = 3'd4
  } chk_state_e;

  // Register length n of the selected sequence.
  function automatic logic [4:0] poly_len(input logic [1:0] sel);
    case (sel)
      2'd0:    return 5'd7;
      2'd1:    return 5'd15;
      default: return 5'd31;
    endcase
  endfunction

  // Second feedback lag t of the selected sequence.
  function automatic logic [4:0] poly_lag(input logic [1:0] sel);
    case (sel)
      2'd0:    return 5'd6;
      2'd1:    return 5'd14;
      default: return 5'd28;
    endcase
  endfunction

  // Predicted next bit: history bit 0 holds the newest bit.
  function automatic logic predict_bit(input logic [HIST_W-1:0] hist,
                                       input logic [1:0] sel);
    return hist[poly_len(sel) - 5'd1] ^ hist[poly_lag(sel) - 5'd1];
  endfunction

endpackage

// File: rtl/prbs_expect_reg.sv
module prbs_expect_reg
  import prbs_chk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       seed_en,
  input  logic       run_en,
  input  logic       rx_bit,
  input  logic [1:0] sel,
  output logic       pred_bit
);

  logic [HIST_W-1:0] hist;

  assign pred_bit = predict_bit(hist, sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist <= '0;
    end else if (clear) begin
      hist <= '0;
    end else if (seed_en) begin
      hist <= {hist[HIST_W-2:0], rx_bit};
    end else if (run_en) begin
      hist <= {hist[HIST_W-2:0], pred_bit};
    end
  end

  AST_SEED_TAKES_RX: assert property (@(posedge clk) disable iff (!rst_n)
    (seed_en && !clear) |=> (hist[0] == $past(rx_bit)));  // R3

  AST_RUN_SELF_FEED: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !seed_en && !clear) |=> (hist[0] == $past(pred_bit)));  // R4

  AST_SEED_RUN_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(seed_en && run_en));  // R3

endmodule

// File: rtl/prbs_window_meter.sv
module prbs_window_meter #(
  parameter int WIN_W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clear,
  input  logic           meas_en,
  input  logic           bit_err,
  input  logic [WIN_W-1:0] win_len,
  input  logic [WIN_W-1:0] err_thresh,
  output logic           win_done,
  output logic           win_pass,
  output logic [WIN_W:0] done_bits,
  output logic [WIN_W:0] done_errs
);

  logic [WIN_W:0] win_bits;
  logic [WIN_W:0] win_errs;
  logic [WIN_W:0] bits_now;
  logic [WIN_W:0] errs_now;

  assign bits_now  = win_bits + {{WIN_W{1'b0}}, 1'b1};
  assign errs_now  = win_errs + {{WIN_W{1'b0}}, bit_err};
  // A zero length ends after one bit because bits_now is at least 1.
  assign win_done  = meas_en && (bits_now >= {1'b0, win_len});
  assign win_pass  = (errs_now <= {1'b0, err_thresh});
  assign done_bits = bits_now;
  assign done_errs = errs_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_bits <= '0;
      win_errs <= '0;
    end else if (clear || win_done) begin
      win_bits <= '0;
      win_errs <= '0;
    end else if (meas_en) begin
      win_bits <= bits_now;
      win_errs <= errs_now;
    end
  end

  AST_WIN_ERRS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    win_errs <= win_bits);  // R5

  AST_WIN_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!meas_en && !clear) |=> ($stable(win_bits) && $stable(win_errs)));  // R10

endmodule

// File: rtl/prbs_phase_ctl.sv
module prbs_phase_ctl
  import prbs_chk_pkg::*;
#(
  parameter int DLY_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             rx_valid,
  input  logic [1:0]       poly_sel,
  input  logic [DLY_W-1:0] init_delay,
  input  logic             win_done,
  input  logic             win_pass,
  output chk_state_e       state,
  output logic [1:0]       sel_q,
  output logic [DLY_W-1:0] delay_code,
  output logic             seed_en,
  output logic             run_en,
  output logic             meas_en
);

  localparam int STEPS = 1 << DLY_W;
  localparam logic [DLY_W-1:0] LAST_TRY = DLY_W'(STEPS - 1);

  logic [4:0]       seed_cnt;
  logic [DLY_W-1:0] tries;
  logic             seed_last;
  logic             last_try;
  logic             step_ev;

  assign seed_en   = (state == ST_SEED) && rx_valid && !start;
  assign run_en    = ((state == ST_MEAS) || (state == ST_LOCK)) && rx_valid && !start;
  assign meas_en   = (state == ST_MEAS) && rx_valid && !start;
  assign seed_last = (seed_cnt == (poly_len(sel_q) - 5'd1));
  assign last_try  = (tries == LAST_TRY);
  assign step_ev   = (state == ST_MEAS) && win_done && !win_pass && !last_try;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      sel_q      <= 2'd0;
      delay_code <= '0;
      tries      <= '0;
      seed_cnt   <= 5'd0;
    end else if (start) begin
      state      <= ST_SEED;
      sel_q      <= poly_sel;
      delay_code <= init_delay;
      tries      <= '0;
      seed_cnt   <= 5'd0;
    end else begin
      case (state)
        ST_SEED: begin
          if (rx_valid) begin
            if (seed_last) begin
              state    <= ST_MEAS;
              seed_cnt <= 5'd0;
            end else begin
              seed_cnt <= seed_cnt + 5'd1;
            end
          end
        end
        ST_MEAS: begin
          if (win_done) begin
            if (win_pass) begin
              state <= ST_LOCK;
            end else if (last_try) begin
              state <= ST_FAIL;
            end else begin
              state      <= ST_SEED;
              delay_code <= delay_code + DLY_W'(1);
              tries      <= tries + DLY_W'(1);
            end
          end
        end
        default: begin
        end
      endcase
    end
  end

  AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (delay_code == $past(init_delay)) && (state == ST_SEED));  // R3

  AST_DELAY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ev && !start) |=> (delay_code == $past(delay_code) + DLY_W'(1))
                            && (state == ST_SEED));  // R6

  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FAIL && !start) |=> (state == ST_FAIL) && $stable(delay_code));  // R7

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOCK && !start) |=> (state == ST_LOCK) && $stable(delay_code));  // R9

  AST_SEED_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SEED) |-> (seed_cnt < poly_len(sel_q)));  // R2

endmodule

// File: rtl/prbs_total_cnt.sv
module prbs_total_cnt #(
  parameter int CNT_W = 32,
  parameter int WIN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             load,
  input  logic             inc,
  input  logic             inc_err,
  input  logic [WIN_W:0]   ld_bits,
  input  logic [WIN_W:0]   ld_errs,
  input  logic             show,
  output logic [CNT_W-1:0] bit_count,
  output logic [CNT_W-1:0] err_count
);

  localparam int MAXW = (CNT_W > WIN_W + 1) ? CNT_W : WIN_W + 1;
  localparam logic [MAXW-1:0] CAP = MAXW'({CNT_W{1'b1}});

  logic [CNT_W-1:0] bits_q;
  logic [CNT_W-1:0] errs_q;

  // Fit a window count into the counter width, saturating.
  function automatic logic [CNT_W-1:0] fit_sat(input logic [WIN_W:0] v);
    logic [MAXW-1:0] ext;
    ext = MAXW'(v);
    if (ext > CAP) ext = CAP;
    return ext[CNT_W-1:0];
  endfunction

  function automatic logic [CNT_W-1:0] step_sat(input logic [CNT_W-1:0] v,
                                                input logic           en);
    if (!en || (v == {CNT_W{1'b1}})) return v;
    return v + CNT_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q <= '0;
      errs_q <= '0;
    end else if (clear) begin
      bits_q <= '0;
      errs_q <= '0;
    end else if (load) begin
      bits_q <= fit_sat(ld_bits);
      errs_q <= fit_sat(ld_errs);
    end else if (inc) begin
      bits_q <= step_sat(bits_q, 1'b1);
      errs_q <= step_sat(errs_q, inc_err);
    end
  end

  assign bit_count = show ? bits_q : '0;
  assign err_count = show ? errs_q : '0;

  AST_COUNT_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load && !clear) |=> (bits_q >= $past(bits_q)) && (errs_q >= $past(errs_q)));  // R9

  AST_ERRS_LE_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    errs_q <= bits_q);  // R9

endmodule

// File: rtl/prbs_phase_checker.sv
module prbs_phase_checker
  import prbs_chk_pkg::*;
#(
  parameter int WIN_W = 16,
  parameter int DLY_W = 3,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             rx_valid,
  input  logic             rx_bit,
  input  logic [1:0]       poly_sel,
  input  logic [DLY_W-1:0] init_delay,
  input  logic [WIN_W-1:0] win_len,
  input  logic [WIN_W-1:0] err_thresh,
  output logic [DLY_W-1:0] delay_code,
  output logic             locked,
  output logic             failed,
  output logic [CNT_W-1:0] bit_count,
  output logic [CNT_W-1:0] err_count
);

  chk_state_e     state;
  logic [1:0]     sel_q;
  logic           seed_en;
  logic           run_en;
  logic           meas_en;
  logic           pred_bit;
  logic           bit_err;
  logic           win_done;
  logic           win_pass;
  logic [WIN_W:0] done_bits;
  logic [WIN_W:0] done_errs;
  logic           lock_load;
  logic           lock_inc;

  assign bit_err   = rx_bit ^ pred_bit;
  assign lock_load = win_done && win_pass;
  assign lock_inc  = run_en && (state == ST_LOCK);
  assign locked    = (state == ST_LOCK);
  assign failed    = (state == ST_FAIL);

  prbs_phase_ctl #(.DLY_W(DLY_W)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .rx_valid   (rx_valid),
    .poly_sel   (poly_sel),
    .init_delay (init_delay),
    .win_done   (win_done),
    .win_pass   (win_pass),
    .state      (state),
    .sel_q      (sel_q),
    .delay_code (delay_code),
    .seed_en    (seed_en),
    .run_en     (run_en),
    .meas_en    (meas_en)
  );

  prbs_expect_reg u_exp (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (start),
    .seed_en  (seed_en),
    .run_en   (run_en),
    .rx_bit   (rx_bit),
    .sel      (sel_q),
    .pred_bit (pred_bit)
  );

  prbs_window_meter #(.WIN_W(WIN_W)) u_win (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (start),
    .meas_en    (meas_en),
    .bit_err    (bit_err),
    .win_len    (win_len),
    .err_thresh (err_thresh),
    .win_done   (win_done),
    .win_pass   (win_pass),
    .done_bits  (done_bits),
    .done_errs  (done_errs)
  );

  prbs_total_cnt #(.CNT_W(CNT_W), .WIN_W(WIN_W)) u_tot (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (start),
    .load      (lock_load),
    .inc       (lock_inc),
    .inc_err   (bit_err),
    .ld_bits   (done_bits),
    .ld_errs   (done_errs),
    .show      (locked),
    .bit_count (bit_count),
    .err_count (err_count)
  );

  AST_LOCK_FAIL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(locked && failed));  // R7

  AST_FAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    failed |-> (bit_count == '0) && (err_count == '0));  // R8

  AST_LOCK_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> (bit_count != '0));  // R9

endmodule

// File: tb/sim_prbs_phase_checker.sv
`timescale 1ns/1ps
module sim_prbs_phase_checker;

  localparam int WIN_W = 16;
  localparam int DLY_W = 3;
  localparam int CNT_W = 8;

  typedef struct packed {
    logic [1:0]  psel;
    logic [1:0]  spoly;
    logic [2:0]  init;
    logic [7:0]  bad;
    logic [15:0] win;
    logic [15:0] thr;
    logic [7:0]  egood;
    logic        exp_lock;
    logic [2:0]  exp_dly;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 2'd0, 3'd0, 8'h00, 16'd32, 16'd0, 8'd0, 1'b1, 3'd0},
    '{2'd1, 2'd1, 3'd5, 8'h60, 16'd40, 16'd2, 8'd2, 1'b1, 3'd7},
    '{2'd2, 2'd2, 3'd6, 8'hC3, 16'd48, 16'd1, 8'd1, 1'b1, 3'd2},
    '{2'd0, 2'd0, 3'd3, 8'hFF, 16'd16, 16'd0, 8'd0, 1'b0, 3'd2},
    '{2'd1, 2'd1, 3'd0, 8'h00, 16'd24, 16'd3, 8'd4, 1'b0, 3'd7},
    '{2'd3, 2'd2, 3'd7, 8'hBF, 16'd20, 16'd0, 8'd0, 1'b1, 3'd6},
    '{2'd0, 2'd0, 3'd1, 8'h02, 16'd0,  16'd0, 8'd0, 1'b1, 3'd2},
    '{2'd0, 2'd1, 3'd4, 8'h00, 16'd32, 16'd2, 8'd0, 1'b0, 3'd3}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic             rx_valid = 1'b0;
  logic             rx_bit = 1'b0;
  logic [1:0]       poly_sel = 2'd0;
  logic [DLY_W-1:0] init_delay = '0;
  logic [WIN_W-1:0] win_len = '0;
  logic [WIN_W-1:0] err_thresh = '0;
  logic [DLY_W-1:0] delay_code;
  logic             locked;
  logic             failed;
  logic [CNT_W-1:0] bit_count;
  logic [CNT_W-1:0] err_count;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [30:0] gs = 31'h7FFF_FFFF;

  always #2.5 clk = ~clk;

  prbs_phase_checker #(.WIN_W(WIN_W), .DLY_W(DLY_W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .rx_valid(rx_valid), .rx_bit(rx_bit),
    .poly_sel(poly_sel), .init_delay(init_delay), .win_len(win_len),
    .err_thresh(err_thresh), .delay_code(delay_code), .locked(locked),
    .failed(failed), .bit_count(bit_count), .err_count(err_count)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Transmitter model: b[k] = b[k-n] ^ b[k-t], newest bit kept in gs[0].
  task automatic gen(input logic [1:0] sp, output logic b);
    case (sp)
      2'd0:    b = gs[6]  ^ gs[5];
      2'd1:    b = gs[14] ^ gs[13];
      default: b = gs[30] ^ gs[27];
    endcase
    gs = {gs[29:0], b};
  endtask

  function automatic int seq_len(input logic [1:0] s);
    return (s == 2'd0) ? 7 : (s == 2'd1) ? 15 : 31;
  endfunction

  // One valid bit, optional flip, then one idle cycle with junk on rx_bit.
  task automatic send(input logic [1:0] sp, input logic flip);
    logic b;
    gen(sp, b);
    rx_valid = 1'b1;
    rx_bit = b ^ flip;
    @(negedge clk);
    rx_valid = 1'b0;
    rx_bit = ~rx_bit;
    @(negedge clk);
  endtask

  task automatic pulse_start(input logic [1:0] ps, input logic [2:0] ini,
                             input logic [15:0] w, input logic [15:0] t);
    poly_sel = ps;
    init_delay = ini;
    win_len = w;
    err_thresh = t;
    rx_valid = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_vec(input int idx, input vec_t v);
    int n, weff, pos, cyc, w;
    logic [2:0] ph;
    logic f, b;
    n = seq_len(v.psel);
    weff = (v.win == 16'd0) ? 1 : int'(v.win);
    pulse_start(v.psel, v.init, v.win, v.thr);
    chk($sformatf("R3 v%0d delay after start", idx), int'(delay_code), int'(v.init));
    chk($sformatf("R3 v%0d locked after start", idx), int'(locked), 0);
    chk($sformatf("R8 v%0d count while searching", idx), int'(bit_count), 0);
    pos = 0;
    cyc = 0;
    while (!locked && !failed && cyc < 5000) begin
      if (cyc % 5 == 4) begin
        rx_valid = 1'b0;
        rx_bit = ~rx_bit;  // R10: ignored bit
      end else begin
        ph = delay_code;
        f = 1'b0;
        if (pos >= n) begin
          w = pos - n;
          f = v.bad[ph] ? 1'b1 : ((w % 2 == 0) && (w / 2 < int'(v.egood)));
        end
        gen(v.spoly, b);
        rx_valid = 1'b1;
        rx_bit = b ^ f;
        pos++;
        if (pos == n + weff) pos = 0;
      end
      cyc++;
      @(negedge clk);
    end
    rx_valid = 1'b0;
    chk($sformatf("R9 v%0d search ended", idx), int'(cyc < 5000), 1);
    chk($sformatf("R9 v%0d locked", idx), int'(locked), int'(v.exp_lock));
    chk($sformatf("R7 v%0d failed", idx), int'(failed), int'(!v.exp_lock));
    chk($sformatf("R6 v%0d delay code", idx), int'(delay_code), int'(v.exp_dly));
    if (v.exp_lock) begin
      chk($sformatf("R5 v%0d bits at lock", idx), int'(bit_count), weff);
      chk($sformatf("R5 v%0d errs at lock", idx), int'(err_count), int'(v.egood));
      for (int k = 0; k < 20; k++) send(v.spoly, (k % 7) == 3);
      chk($sformatf("R10 v%0d bits after lock", idx), int'(bit_count), weff + 20);
      chk($sformatf("R4 v%0d errs after lock", idx), int'(err_count), int'(v.egood) + 3);
      chk($sformatf("R9 v%0d still locked", idx), int'(locked), 1);
    end else begin
      for (int k = 0; k < 10; k++) send(v.spoly, 1'b0);
      chk($sformatf("R8 v%0d bits when failed", idx), int'(bit_count), 0);
      chk($sformatf("R8 v%0d errs when failed", idx), int'(err_count), 0);
      chk($sformatf("R7 v%0d failed holds", idx), int'(failed), 1);
      chk($sformatf("R7 v%0d delay holds", idx), int'(delay_code), int'(v.exp_dly));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 delay in reset", int'(delay_code), 0);
    chk("R1 locked in reset", int'(locked), 0);
    chk("R1 failed in reset", int'(failed), 0);
    chk("R1 bits in reset", int'(bit_count), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 errs after reset", int'(err_count), 0);

    // Table walk: R2 sequences, R5 windows, R6 sweep, R7 failure.
    for (int i = 0; i < NVEC; i++) run_vec(i, VECS[i]);

    // Saturation after lock, window of one bit on PRBS7 (R9).
    pulse_start(2'd0, 3'd4, 16'd1, 16'd0);
    for (int k = 0; k < 8; k++) send(2'd0, 1'b0);
    chk("R9 sat lock", int'(locked), 1);
    chk("R9 sat lock delay", int'(delay_code), 4);
    for (int k = 0; k < 300; k++) send(2'd0, 1'b1);
    chk("R9 bits saturate", int'(bit_count), 255);
    chk("R9 errs saturate", int'(err_count), 255);

    // Restart drops lock and counts (R9, R8).
    pulse_start(2'd1, 3'd2, 16'd8, 16'd0);
    chk("R9 start clears lock", int'(locked), 0);
    chk("R8 start clears bits", int'(bit_count), 0);
    chk("R3 restart delay", int'(delay_code), 2);

    // Mid-run reset returns to the reset state (R1).
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 delay after mid reset", int'(delay_code), 0);
    chk("R1 failed after mid reset", int'(failed), 0);
    rst_n = 1'b1;
    @(negedge clk);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule